// File: doc/BRIEF.md
# Serial Audio Link Command and Control

This block holds the command word that software composes to reach a register inside an external audio codec on a serial audio link. The word has a read/write flag, a 7-bit codec register address and a codec select. The block presents these fields in the positions the frame serializer needs for output slot 0 and slot 1. It also stores two power-down semaphore bits. Audio and modem drivers use these bits to coordinate with each other, and the hardware never acts on them.

The block also runs the shutdown and wake-up of the link. When software sets the shutdown flag, both codec-ready status flags clear. When software requests a warm reset, the block drives a SYNC-high request for a programmable number of system clocks. It then releases SYNC and watches the serial bit clock, which is synchronized into the system clock domain. Once it has counted a set number of bit-clock edges, hardware clears the warm-reset flag. Starting a warm reset also clears the shutdown flag.

Software reaches the block through a simple register bus. Writes take effect at the next clock edge. Reads are combinational. Word 0 is the control word. Word 1 is the status word, where bit 0 is the primary codec-ready flag and bit 1 is the secondary codec-ready flag.

Top module: `acl_cmd_ctrl`

## Requirements
- R1: After reset, the control word and the status word both read 0, and `sync_force_o` and `link_down_o` are low.
- R2: The control word at bus address 0 uses these fields: bit 31 is the direction (0 write, 1 read), bits 30:24 are the register address, bits 23:22 are the codec select, bit 21 is the primary semaphore and bit 20 is the secondary semaphore. These fields read back as written. Bit 19 and bits 16:0 always read 0.
- R3: `slot1_cmd_o[7]` equals the direction bit and `slot1_cmd_o[6:0]` equals the register address. These are slot 1 bits 19:12. The value changes only after a write to the control word.
- R4: `slot0_id_o` equals the codec select (00 primary, 01 secondary, 10 third, 11 fourth). This is slot 0 bits 1:0.
- R5: `slot0_tag_o` (slot 0 bits 14:13) equals `slot_valid_i` when the codec select is 00. It is 00 when the codec select is nonzero, whatever `slot_valid_i` is. The semaphore bits have no effect on any slot output.
- R6: A one-cycle high on `rdy_pulse_i[0]` or `rdy_pulse_i[1]` sets status bit 0 or status bit 1 at the next edge. The flag then holds.
- R7: A control write with bit 18 (shutdown) set clears both status flags at the next edge, even if a ready pulse arrives in the same cycle. `link_down_o` then stays high until software writes bit 18 as 0 or a warm reset starts.
- R8: A control write with bit 17 (warm reset) set, made while no warm reset is pending, sets bit 17 and clears bit 18 at the next edge. `sync_force_o` is high for exactly SYNC_CYCLES cycles, starting at that edge.
- R9: After SYNC is released, bit 17 stays set until EDGE_COUNT bit-clock rising edges have been seen. Fewer edges leave it set. The bit then clears without any software action.
- R10: While a warm reset is pending, control writes do not change bit 17 and do not restart SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | REG_AW | Register word address (0 control, 1 status) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| rdy_pulse_i | input | 2 | Codec-ready pulses from the link receiver (bit 0 primary) |
| slot_valid_i | input | 2 | Slot 1 (bit 1) and slot 2 (bit 0) valid requests |
| bitclk_i | input | 1 | Serial bit clock, asynchronous to `clk_i` |
| slot0_tag_o | output | 2 | Slot 0 bits 14:13 |
| slot0_id_o | output | 2 | Slot 0 bits 1:0, codec select |
| slot1_cmd_o | output | 8 | Slot 1 bits 19:12, direction and register address |
| link_down_o | output | 1 | Link shutdown flag |
| sync_force_o | output | 1 | Warm-reset SYNC-high request |

## Verification
The slot outputs and the read data are combinational from stored fields. Every stored field takes its new value at the edge that ends the write cycle. The bench therefore drives a write for one cycle and samples on the following falling edge, once all state has settled.

The ready flags and the shutdown clear also land one edge after their stimulus. `sync_force_o` rises at the same edge as the warm-reset write, so the bench counts the falling edges at which it is high.

A bit-clock edge passes through two synchronizer flops and one edge-detect flop before it clears the warm flag. The bench therefore waits a margin of at least ten cycles after the last edge before it reads bit 17.

// File: rtl/acl_pkg.sv
package acl_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned CADDR_W  = 7;
   localparam int unsigned B_DIR    = 31;
   localparam int unsigned B_ADDR_L = 24;
   localparam int unsigned B_SEL_L  = 22;
   localparam int unsigned B_SEM_P  = 21;
   localparam int unsigned B_SEM_S  = 20;
   localparam int unsigned B_SHUT   = 18;
   localparam int unsigned B_WARM   = 17;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SYNC = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic               dir;
      logic [CADDR_W-1:0] caddr;
      logic [1:0]         sel;
      logic               sem_p;
      logic               sem_s;
      logic               shut;
      logic               warm;
   } ctrl_t;
endpackage

// File: rtl/acl_bitclk_edge.sv
module acl_bitclk_edge #(
   parameter int unsigned STAGES     = 2,
   parameter bit          BOTH_EDGES = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bitclk_i,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("acl_bitclk_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], bitclk_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   if (BOTH_EDGES) begin : g_both
      assign edge_o = sync_q[STAGES-1] ^ prev_q;
   end else begin : g_rise
      assign edge_o = sync_q[STAGES-1] & ~prev_q;
   end
endmodule

// File: rtl/acl_warm_seq.sv
module acl_warm_seq
   import acl_pkg::*;
#(
   parameter int unsigned SYNC_CYCLES = 100,
   parameter int unsigned EDGE_COUNT  = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic edge_i,
   output logic sync_o,
   output logic done_o
);
   localparam int unsigned SC_W = $clog2(SYNC_CYCLES + 1);
   localparam int unsigned EC_W = $clog2(EDGE_COUNT + 1);
   localparam logic [SC_W-1:0] SC_LAST = SC_W'(SYNC_CYCLES - 1);
   localparam logic [EC_W-1:0] EC_LAST = EC_W'(EDGE_COUNT - 1);

   if (SYNC_CYCLES < 1) begin : g_bad_sync
      $error("acl_warm_seq: SYNC_CYCLES must be at least 1");
   end
   if (EDGE_COUNT < 1) begin : g_bad_edge
      $error("acl_warm_seq: EDGE_COUNT must be at least 1");
   end

   seq_state_e      state_q;
   logic [SC_W-1:0] scnt_q;
   logic [EC_W-1:0] ecnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         scnt_q  <= '0;
         ecnt_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  state_q <= SEQ_SYNC;
                  scnt_q  <= '0;
               end
            end
            SEQ_SYNC: begin
               if (scnt_q == SC_LAST) begin
                  state_q <= SEQ_WAIT;
                  ecnt_q  <= '0;
               end else begin
                  scnt_q <= scnt_q + 1'b1;
               end
            end
            SEQ_WAIT: begin
               if (edge_i) begin
                  if (ecnt_q == EC_LAST) state_q <= SEQ_IDLE;
                  else                   ecnt_q  <= ecnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign sync_o = (state_q == SEQ_SYNC);
   assign done_o = (state_q == SEQ_WAIT) && edge_i && (ecnt_q == EC_LAST);
endmodule

// File: rtl/acl_cmd_regs.sv
module acl_cmd_regs
   import acl_pkg::*;
#(
   parameter int unsigned REG_AW = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   input  logic [1:0]        rdy_pulse_i,
   input  logic              warm_done_i,
   output logic              warm_start_o,
   output ctrl_t             ctrl_o,
   output logic [1:0]        rdy_o
);
   if (REG_AW < 1) begin : g_bad_aw
      $error("acl_cmd_regs: REG_AW must be at least 1");
   end

   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(1);

   ctrl_t      ctrl_q;
   logic [1:0] rdy_q;
   logic       wr_ctrl;

   assign wr_ctrl      = we_i && (addr_i == A_CTRL);
   assign warm_start_o = wr_ctrl && wdata_i[B_WARM] && !ctrl_q.warm;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         rdy_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.dir   <= wdata_i[B_DIR];
            ctrl_q.caddr <= wdata_i[B_ADDR_L +: CADDR_W];
            ctrl_q.sel   <= wdata_i[B_SEL_L +: 2];
            ctrl_q.sem_p <= wdata_i[B_SEM_P];
            ctrl_q.sem_s <= wdata_i[B_SEM_S];
            ctrl_q.shut  <= warm_start_o ? 1'b0 : wdata_i[B_SHUT];
         end
         if (warm_start_o)     ctrl_q.warm <= 1'b1;
         else if (warm_done_i) ctrl_q.warm <= 1'b0;

         if (wr_ctrl && wdata_i[B_SHUT]) rdy_q <= '0;
         else                            rdy_q <= rdy_q | rdy_pulse_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_CTRL) begin
         rdata_o[B_DIR]                = ctrl_q.dir;
         rdata_o[B_ADDR_L +: CADDR_W]  = ctrl_q.caddr;
         rdata_o[B_SEL_L +: 2]         = ctrl_q.sel;
         rdata_o[B_SEM_P]              = ctrl_q.sem_p;
         rdata_o[B_SEM_S]              = ctrl_q.sem_s;
         rdata_o[B_SHUT]               = ctrl_q.shut;
         rdata_o[B_WARM]               = ctrl_q.warm;
      end else if (addr_i == A_STAT) begin
         rdata_o[1:0] = rdy_q;
      end
   end

   assign ctrl_o = ctrl_q;
   assign rdy_o  = rdy_q;
endmodule

// File: rtl/acl_cmd_ctrl.sv
module acl_cmd_ctrl
   import acl_pkg::*;
#(
   parameter int unsigned REG_AW      = 2,
   parameter int unsigned SYNC_CYCLES = 100,
   parameter int unsigned EDGE_COUNT  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          BOTH_EDGES  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [REG_AW-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [1:0]        rdy_pulse_i,
   input  logic [1:0]        slot_valid_i,
   input  logic              bitclk_i,
   output logic [1:0]        slot0_tag_o,
   output logic [1:0]        slot0_id_o,
   output logic [7:0]        slot1_cmd_o,
   output logic              link_down_o,
   output logic              sync_force_o
);
   ctrl_t      ctrl;
   logic [1:0] rdy_flags;
   logic       warm_start;
   logic       warm_done;
   logic       bclk_edge;

   acl_cmd_regs #(.REG_AW(REG_AW)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (bus_we_i),
      .addr_i       (bus_addr_i),
      .wdata_i      (bus_wdata_i),
      .rdata_o      (bus_rdata_o),
      .rdy_pulse_i  (rdy_pulse_i),
      .warm_done_i  (warm_done),
      .warm_start_o (warm_start),
      .ctrl_o       (ctrl),
      .rdy_o        (rdy_flags)
   );

   acl_bitclk_edge #(.STAGES(SYNC_STAGES), .BOTH_EDGES(BOTH_EDGES)) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bitclk_i (bitclk_i),
      .edge_o   (bclk_edge)
   );

   acl_warm_seq #(.SYNC_CYCLES(SYNC_CYCLES), .EDGE_COUNT(EDGE_COUNT)) u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (warm_start),
      .edge_i  (bclk_edge),
      .sync_o  (sync_force_o),
      .done_o  (warm_done)
   );

   assign slot1_cmd_o = {ctrl.dir, ctrl.caddr};
   assign slot0_id_o  = ctrl.sel;
   assign slot0_tag_o = (ctrl.sel != 2'b00) ? 2'b00 : slot_valid_i;
   assign link_down_o = ctrl.shut;
endmodule

// File: rtl/acl_cmd_ctrl_chk.sv
module acl_cmd_ctrl_chk #(
   parameter int unsigned REG_AW      = 2,
   parameter int unsigned SYNC_CYCLES = 100
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_we_i,
   input logic [REG_AW-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [1:0]        rdy_pulse_i,
   input logic [1:0]        slot0_tag_o,
   input logic [1:0]        slot0_id_o,
   input logic [7:0]        slot1_cmd_o,
   input logic              link_down_o,
   input logic              sync_force_o,
   input logic [1:0]        rdy_flags,
   input logic              warm_flag,
   input logic              bclk_edge
);
   localparam int unsigned RW = $clog2(SYNC_CYCLES + 2);
   logic [RW-1:0] run_q;
   logic          wr_ctrl;

   assign wr_ctrl = bus_we_i && (bus_addr_i == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           run_q <= '0;
      else if (sync_force_o) run_q <= run_q + 1'b1;
      else                   run_q <= '0;
   end

   assert_slot1_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_ctrl |=> $stable(slot1_cmd_o));

   assert_tag_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot0_id_o != 2'b00) |-> (slot0_tag_o == 2'b00));

   assert_rdy_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdy_pulse_i[0] && !(wr_ctrl && bus_wdata_i[18])) |=> rdy_flags[0]);

   assert_shut_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ctrl && bus_wdata_i[18]) |=> (rdy_flags == 2'b00));

   assert_sync_no_shut_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_force_o |-> (!link_down_o && warm_flag));

   assert_sync_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RW'(SYNC_CYCLES));

   assert_warm_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(warm_flag) |-> $past(bclk_edge));

   assert_warm_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_flag && !bclk_edge) |=> warm_flag);
endmodule

bind acl_cmd_ctrl acl_cmd_ctrl_chk #(.REG_AW(REG_AW), .SYNC_CYCLES(SYNC_CYCLES)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_we_i     (bus_we_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .rdy_pulse_i  (rdy_pulse_i),
   .slot0_tag_o  (slot0_tag_o),
   .slot0_id_o   (slot0_id_o),
   .slot1_cmd_o  (slot1_cmd_o),
   .link_down_o  (link_down_o),
   .sync_force_o (sync_force_o),
   .rdy_flags    (rdy_flags),
   .warm_flag    (ctrl.warm),
   .bclk_edge    (bclk_edge)
);

// File: tb/acl_cmd_ctrl_tb.sv
module acl_cmd_ctrl_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  SYNC_N     = 8;
   localparam int  EDGE_N     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  rdy_pulse = '0;
   logic [1:0]  svalid = '0;
   logic        bitclk = 1'b0;
   logic [1:0]  tag, cid;
   logic [7:0]  cmd;
   logic        ldown, syncf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acl_cmd_ctrl #(.REG_AW(2), .SYNC_CYCLES(SYNC_N), .EDGE_COUNT(EDGE_N)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rdy_pulse_i(rdy_pulse),
      .slot_valid_i(svalid), .bitclk_i(bitclk), .slot0_tag_o(tag),
      .slot0_id_o(cid), .slot1_cmd_o(cmd), .link_down_o(ldown),
      .sync_force_o(syncf)
   );

   typedef struct packed {
      logic [31:0] wd;
      logic [1:0]  sv;
      logic [7:0]  e_cmd;
      logic [1:0]  e_id;
      logic [1:0]  e_tag;
      logic [31:0] e_rd;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{32'h8000_0000, 2'b11, 8'h80, 2'b00, 2'b11, 32'h8000_0000},
      '{32'h7F00_0000, 2'b10, 8'h7F, 2'b00, 2'b10, 32'h7F00_0000},
      '{32'hA540_0000, 2'b11, 8'hA5, 2'b01, 2'b00, 32'hA540_0000},
      '{32'h12B8_FFFF, 2'b01, 8'h12, 2'b10, 2'b00, 32'h12B0_0000},
      '{32'hFFF0_0000, 2'b11, 8'hFF, 2'b11, 2'b00, 32'hFFF0_0000},
      '{32'h0030_0000, 2'b01, 8'h00, 2'b00, 2'b01, 32'h0030_0000},
      '{32'h0000_0000, 2'b00, 8'h00, 2'b00, 2'b00, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; addr = 2'd0; wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = 2'd0;
   endtask

   task automatic bclk_rise();
      bitclk = 1'b1;
      repeat (3) @(negedge clk);
      bitclk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd;
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd0, rd); check("R1 ctrl", rd, 32'h0);
      bus_read(2'd1, rd); check("R1 status", rd, 32'h0);
      check("R1 sync", {31'b0, syncf}, 32'h0);
      check("R1 linkdown", {31'b0, ldown}, 32'h0);

      // R2 R3 R4 R5 vector table
      for (int i = 0; i < 7; i++) begin
         svalid = VECS[i].sv;
         bus_write(2'd0, VECS[i].wd);
         bus_read(2'd0, rd);
         check("R2 readback", rd, VECS[i].e_rd);
         check("R3 slot1", {24'b0, cmd}, {24'b0, VECS[i].e_cmd});
         check("R4 slot0 id", {30'b0, cid}, {30'b0, VECS[i].e_id});
         check("R5 slot0 tag", {30'b0, tag}, {30'b0, VECS[i].e_tag});
      end
      // R3: a status write must not disturb slot1
      bus_write(2'd0, 32'hC300_0000);
      bus_write(2'd1, 32'hFFFF_FFFF);
      check("R3 hold", {24'b0, cmd}, 32'h0000_00C3);
      bus_write(2'd0, 32'h0);

      // R6 ready flags
      @(negedge clk); rdy_pulse = 2'b01;
      @(negedge clk); rdy_pulse = 2'b00;
      bus_read(2'd1, rd); check("R6 primary", rd, 32'h1);
      @(negedge clk); rdy_pulse = 2'b10;
      @(negedge clk); rdy_pulse = 2'b00;
      repeat (3) @(negedge clk);
      bus_read(2'd1, rd); check("R6 both hold", rd, 32'h3);

      // R7 shutdown with a simultaneous ready pulse
      @(negedge clk);
      we = 1'b1; addr = 2'd0; wdata = 32'h0004_0000; rdy_pulse = 2'b11;
      @(negedge clk);
      we = 1'b0; wdata = '0; rdy_pulse = 2'b00;
      bus_read(2'd1, rd); check("R7 flags cleared", rd, 32'h0);
      check("R7 linkdown", {31'b0, ldown}, 32'h1);
      repeat (5) @(negedge clk);
      check("R7 linkdown holds", {31'b0, ldown}, 32'h1);

      // R8 warm reset start
      @(negedge clk);
      we = 1'b1; addr = 2'd0; wdata = 32'h0006_0000;
      @(negedge clk);
      we = 1'b0; wdata = '0;
      bus_read(2'd0, rd); check("R8 ctrl warm set shut clear", rd, 32'h0002_0000);
      check("R8 linkdown", {31'b0, ldown}, 32'h0);
      hi = 0;
      for (int k = 0; k < SYNC_N + 6; k++) begin
         if (syncf) hi++;
         if (k == 1) begin
            // R10: writes while pending do not clear warm nor restart SYNC
            we = 1'b1; addr = 2'd0; wdata = 32'h0002_0000;
         end else begin
            we = 1'b0; wdata = '0;
         end
         @(negedge clk);
      end
      check("R8 sync length", hi, SYNC_N);
      bus_write(2'd0, 32'h0000_0000);
      bus_read(2'd0, rd); check("R10 warm kept", rd, 32'h0002_0000);
      check("R10 no resync", {31'b0, syncf}, 32'h0);

      // R9 fewer edges leave warm set
      for (int e = 0; e < EDGE_N - 1; e++) bclk_rise();
      repeat (10) @(negedge clk);
      bus_read(2'd0, rd); check("R9 pending", rd, 32'h0002_0000);
      bclk_rise();
      repeat (10) @(negedge clk);
      bus_read(2'd0, rd); check("R9 cleared", rd, 32'h0);
      check("R9 sync idle", {31'b0, syncf}, 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule